// File: doc/BRIEF.md
# Converter Out-of-Range Flag Generator

This block watches a stream of signed 14-bit converter samples, one per clock, and produces a single out-of-range flag that stays aligned with a delayed data path.

The block has two modes. In the default mode the flag copies an external full-scale clip indication, delayed by a long fixed latency. In the early-warning mode the flag rises sooner. It does so when the magnitude of the sample reaches one of eight programmable thresholds below full scale.

Mode and threshold are captured together with each sample. Each flag therefore belongs to the sample that produced it, even across a change of setting. A system uses the early-warning mode to react to large signals before the full data pipeline has delivered them, for example to drive a gain-control loop.

Top module: `ovr_flag_gen`

## Requirements
- R1: A synchronous active-high reset clears both delay lines. The flag reads 0 on the first clock after reset is seen, and stays 0 until a flagged sample has crossed its path.
- R2: A sample captured with `fast_en`=0 and `clip_in`=1 drives `ovr_flag` to 1 after 14 rising edges, counting the capturing edge as the first.
- R3: With `fast_en`=0 the sample value has no effect. A full-scale sample captured with `clip_in`=0 leaves the flag at 0.
- R4: A sample captured with `fast_en`=1 drives `ovr_flag` after 4 rising edges, counting the capturing edge as the first. The flag is 1 exactly when the magnitude of the sample is at least the selected threshold.
- R5: With `fast_en`=1 the `clip_in` input has no effect. A small sample captured with `clip_in`=1 gives a flag of 0.
- R6: `thr_sel` codes 0 to 7 select magnitude thresholds 768, 1280, 2304, 3328, 4352, 5376, 6400 and 7424. These correspond to about -20.6, -16.1, -11.0, -7.8, -5.5, -3.7, -2.1 and -0.9 dB of full scale (8192).
- R7: The magnitude compare is symmetric and inclusive. Threshold-1 and -(threshold-1) are not flagged, while threshold and -threshold are flagged. The most negative code, -8192, is flagged at every threshold.
- R8: Mode and threshold apply to the sample entering on the same edge, and samples in flight are kept. The flag at any cycle is the OR of the default-path result of the sample 14 edges back and the early-path result of the sample 4 edges back.
- R9: A reset asserted in the middle of a stream discards every flag in flight. After reset is released, only new samples can set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample | input | 14 | Two's-complement converter sample |
| clip_in | input | 1 | Full-scale clip indication for this sample |
| fast_en | input | 1 | 1 selects the early threshold path |
| thr_sel | input | 3 | Early-path threshold code |
| ovr_flag | output | 1 | Out-of-range flag |

## Verification
The hardest situation to reach is the overlap after a mode change. Default-mode samples are still travelling down the long line while newer early-mode samples come out of the short line. The flag must then be the OR of both. The stimulus toggles `fast_en` every cycle and every few cycles. It gives the clip and magnitude conditions independent patterns, so the two contributions land on the same output cycle in every combination. Each threshold is also probed at exactly threshold-1 and threshold, at both signs, and with the most negative code.

// File: rtl/ovr_flag_gen.sv
module ovr_flag_gen #(
  parameter int DW       = 14,
  parameter int SLOW_LAT = 14,
  parameter int FAST_LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sample,
  input  logic          clip_in,
  input  logic          fast_en,
  input  logic [2:0]    thr_sel,
  output logic          ovr_flag
);

  // thresholds are k/32 of full scale, k = 3,5,9,...,29
  logic [4:0]    thr_k;
  logic [DW-1:0] thr;
  logic [DW-1:0] mag;
  logic          fast_hit;
  logic          slow_hit;

  assign thr_k    = (thr_sel == 3'd0) ? 5'd3 : {thr_sel, 2'b01};
  assign thr      = {1'b0, thr_k, {(DW-6){1'b0}}};
  assign mag      = sample[DW-1] ? ((~sample) + DW'(1)) : sample;
  assign fast_hit = fast_en && (mag >= thr);
  assign slow_hit = !fast_en && clip_in;

  logic [SLOW_LAT-1:0] slow_pipe;
  logic [FAST_LAT-1:0] fast_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_pipe <= '0;
      fast_pipe <= '0;
    end else begin
      slow_pipe <= {slow_pipe[SLOW_LAT-2:0], slow_hit};
      fast_pipe <= {fast_pipe[FAST_LAT-2:0], fast_hit};
    end
  end

  assign ovr_flag = slow_pipe[SLOW_LAT-1] | fast_pipe[FAST_LAT-1];

endmodule

module ovr_flag_gen_chk #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] sample,
  input logic          clip_in,
  input logic          fast_en,
  input logic          ovr_flag
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

  logic [4:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (run_cnt != 5'd31) run_cnt <= run_cnt + 5'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !ovr_flag);

  p_slow_clip_r2: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 5'd14 && $past(clip_in && !fast_en, 14)) |-> ovr_flag);

  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 5'd14 && !$past(clip_in && !fast_en, 14) && !$past(fast_en, 4))
      |-> !ovr_flag);

  p_fast_ignores_clip_r5: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 5'd14 && $past(fast_en, 4) && $past(sample, 4) == '0 && $past(fast_en, 14))
      |-> !ovr_flag);

  p_most_neg_r7: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 5'd4 && $past(fast_en, 4) && $past(sample, 4) == MOST_NEG) |-> ovr_flag);
endmodule

bind ovr_flag_gen ovr_flag_gen_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sample(sample), .clip_in(clip_in),
  .fast_en(fast_en), .ovr_flag(ovr_flag)
);

// File: tb/tb_ovr_flag_gen.sv
`timescale 1ns/1ps
module tb_ovr_flag_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] sample = '0;
  logic        clip_in = 1'b0;
  logic        fast_en = 1'b0;
  logic [2:0]  thr_sel = '0;
  logic        ovr_flag;

  int n_checks = 0;
  int n_fails  = 0;

  bit    slow_q[$];
  bit    fast_q[$];
  string slow_t[$];
  string fast_t[$];

  always #2 clk = ~clk;

  ovr_flag_gen dut (
    .clk(clk), .rst(rst), .sample(sample), .clip_in(clip_in),
    .fast_en(fast_en), .thr_sel(thr_sel), .ovr_flag(ovr_flag)
  );

  function automatic int thr_of(input int sel);
    int t[8] = '{768, 1280, 2304, 3328, 4352, 5376, 6400, 7424};
    return t[sel];
  endfunction

  function automatic int mag_of(input logic [13:0] s);
    int v = $signed(s);
    return (v < 0) ? -v : v;
  endfunction

  task automatic init_queues();
    slow_q.delete(); fast_q.delete(); slow_t.delete(); fast_t.delete();
    repeat (14) begin slow_q.push_back(1'b0); slow_t.push_back("R1"); end
    repeat (4)  begin fast_q.push_back(1'b0); fast_t.push_back("R1"); end
  endtask

  // monitor pop/compare, then drive and push expectation for this sample
  task automatic step(input logic [13:0] s, input logic c, input logic f,
                      input logic [2:0] sel, input string tag);
    bit    es, ef, exp_v;
    string ts, tf;
    es = slow_q.pop_front(); ts = slow_t.pop_front();
    ef = fast_q.pop_front(); tf = fast_t.pop_front();
    exp_v = es | ef;
    n_checks++;
    if (ovr_flag !== exp_v) begin
      n_fails++;
      $display("FAIL %s/%s ovr_flag=%b expected %b", ts, tf, ovr_flag, exp_v);
    end
    sample = s; clip_in = c; fast_en = f; thr_sel = sel;
    slow_q.push_back(!f && c);
    fast_q.push_back(f && (mag_of(s) >= thr_of(sel)));
    slow_t.push_back(tag);
    fast_t.push_back(tag);
  endtask

  task automatic drive(input logic [13:0] s, input logic c, input logic f,
                       input logic [2:0] sel, input string tag);
    @(negedge clk);
    step(s, c, f, sel, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (ovr_flag !== 1'b0) begin
      n_fails++;
      $display("FAIL %s ovr_flag=%b expected 0 during reset", tag, ovr_flag);
    end
    init_queues();
    rst = 1'b0;
    step(14'd0, 1'b0, 1'b0, 3'd0, tag);
  endtask

  task automatic flush();
    repeat (16) drive(14'd0, 1'b0, 1'b0, 3'd0, "R1");
  endtask

  initial begin
    #(200000 * 4);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    init_queues();
    do_reset("R1");
    flush();

    // R2: clip pattern in default mode
    for (int i = 0; i < 40; i++)
      drive(14'($urandom), (i % 5 == 0) || (i % 7 == 3), 1'b0, 3'd7, "R2");
    // R3: full-scale samples without clip
    for (int i = 0; i < 20; i++)
      drive((i % 2) ? 14'h1FFF : 14'h2000, 1'b0, 1'b0, 3'd0, "R3");
    flush();

    // R4/R6/R7: boundaries at every threshold, both signs
    for (int sel = 0; sel < 8; sel++) begin
      int t = thr_of(sel);
      drive(14'(t - 1),  1'b0, 1'b1, 3'(sel), "R6");
      drive(14'(t),      1'b0, 1'b1, 3'(sel), "R4");
      drive(14'(-t),     1'b0, 1'b1, 3'(sel), "R7");
      drive(14'(-(t-1)), 1'b0, 1'b1, 3'(sel), "R7");
      drive(14'h2000,    1'b0, 1'b1, 3'(sel), "R7");
      drive(14'(t + 1),  1'b0, 1'b1, 3'(sel), "R6");
    end
    // R5: clip ignored in early mode
    for (int i = 0; i < 20; i++)
      drive(14'(i * 11), 1'b1, 1'b1, 3'(i % 8), "R5");
    // R4: random magnitudes and thresholds
    for (int i = 0; i < 60; i++)
      drive(14'($urandom), 1'($urandom), 1'b1, 3'($urandom), "R4");
    flush();

    // R8: mode toggling with overlapping paths
    for (int i = 0; i < 80; i++)
      drive(14'($urandom), 1'($urandom), (i % 3 == 0) || (i % 11 < 4),
            3'($urandom), "R8");
    for (int i = 0; i < 30; i++)
      drive((i % 2) ? 14'h2000 : 14'd5, 1'b1, 1'(i % 2), 3'd0, "R8");
    flush();

    // R9: reset with flags in flight
    for (int i = 0; i < 10; i++) drive(14'h2000, 1'b1, 1'b0, 3'd0, "R9");
    drive(14'h2000, 1'b1, 1'b1, 3'd0, "R9");
    do_reset("R9");
    flush();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule